// File: doc/BRIEF.md
# Segment Descriptor Protection Checker

This block keeps one 64-bit segment descriptor in a cache register and screens every memory access made through it. The access either produces a 32-bit linear address or returns a fault code. The block has two checked phases.

The load phase receives the raw descriptor, the requested privilege of the selector, the current privilege level and whether the segment is going into the code slot. It checks three things: the descriptor class, presence and privilege. If all three pass, the descriptor becomes the active segment.

The access phase takes an offset and an operation code. It checks the access rights and the segment limit, then adds the offset to the segment base. The first successful access to a segment whose accessed flag is clear sets that flag in the cached copy. The same access raises a one-cycle write-back request that carries the updated descriptor image.

Descriptor fields used:

| Field | Bits |
|---|---|
| Limit | 15:0 and 51:48 |
| Base | 39:16 and 63:56 |
| Accessed flag | 40 |
| Read/write enable | 41 |
| Direction or conforming | 42 |
| Executable | 43 |
| Class flag S | 44 |
| DPL | 46:45 |
| Present | 47 |
| Granularity | 55 |

Fault codes on both fault outputs:

| Code | Meaning |
|---|---|
| 0 | none |
| 1 | class |
| 2 | not present |
| 3 | privilege |
| 4 | limit |
| 5 | rights |
| 6 | no usable segment |

Top module: `seg_guard`

## Requirements
- R1: A successful access returns `ac_addr` = {desc[63:56], desc[39:16]} + `ac_off`, modulo 2^32.
- R2: The raw limit is {desc[51:48], desc[15:0]}. When desc[55] is 1, the effective limit is the raw limit shifted left by 12 with the low 12 bits set to ones. Otherwise it is the raw limit itself.
- R3: A load gives fault 1 (class) in three cases: desc[44] is 0; `ld_code`=1 and desc[43] is 0; or `ld_code`=0 and desc[43]=1 and desc[41]=0.
- R4: A load with desc[47]=0 gives fault 2. After any failed load, every access returns fault 6 with address 0 until a load succeeds.
- R5: A data load (`ld_code`=0) needs max(`ld_cpl`, `ld_rpl`) <= DPL. A code load with desc[42]=1 (conforming) needs `ld_cpl` >= DPL. A code load with desc[42]=0 needs `ld_cpl` == DPL. Any violation gives fault 3.
- R6: Load faults are prioritised class, then not present, then privilege.
- R7: Access operation codes on `ac_op` are 0 = read, 1 = write, 2 = fetch and 3 = invalid. A write needs a data segment (desc[43]=0) with desc[41]=1. A read needs a data segment, or a code segment with desc[41]=1. A fetch needs a code segment. Code 3 is always refused. Any violation gives fault 5.
- R8: A data segment with desc[42]=1 is expand-down: an offset is valid only if it is strictly greater than the effective limit. Every other segment accepts offsets less than or equal to the effective limit. A violation gives fault 4.
- R9: Access faults are prioritised no segment (6), then rights (5), then limit (4). `ac_addr` is 0 whenever `ac_fault` is non-zero.
- R10: On the first fault-free access to a segment whose bit 40 is clear, `wb_req` pulses for one cycle together with `ac_done`. `wb_desc` then holds the descriptor with bit 40 set, and later accesses produce no pulse. An access in the same cycle as a load neither sets the flag nor requests a write-back.
- R11: `ld_done` and `ac_done` pulse one cycle after `ld_valid` and `ac_valid`. After reset all outputs are 0 and no segment is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request |
| ld_desc | input | 64 | Raw descriptor |
| ld_code | input | 1 | 1 = code slot, 0 = data/stack slot |
| ld_rpl | input | 2 | Selector requested privilege |
| ld_cpl | input | 2 | Current privilege level |
| ld_done | output | 1 | Load result valid |
| ld_fault | output | 3 | Load fault code |
| ac_valid | input | 1 | Access request |
| ac_op | input | 2 | 0 read, 1 write, 2 fetch, 3 invalid |
| ac_off | input | 32 | Offset into segment |
| ac_done | output | 1 | Access result valid |
| ac_fault | output | 3 | Access fault code |
| ac_addr | output | 32 | Linear address, 0 on fault |
| wb_req | output | 1 | Accessed-flag write-back pulse |
| wb_desc | output | 64 | Descriptor image to write back |

## Verification
The bench probes each limit edge on both sides: the last valid offset and the first invalid one, for byte and page granularity. An off-by-one comparator would accept one byte past the limit, or reject the final byte. For expand-down segments it tests an offset equal to the limit, the next offset, and the top of the address space. A design that did not invert the comparison would accept the limit itself. The shared rights bit is driven under both segment kinds, so a decoder that ignored the executable bit would let writes into code or refuse reads of data. Descriptors with several faults at once show whether the priority order holds. Repeated accesses show whether the write-back request fires more than once.

// File: rtl/seg_guard.sv
module seg_guard (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_valid,
  input  logic [63:0] ld_desc,
  input  logic        ld_code,
  input  logic [1:0]  ld_rpl,
  input  logic [1:0]  ld_cpl,
  output logic        ld_done,
  output logic [2:0]  ld_fault,
  input  logic        ac_valid,
  input  logic [1:0]  ac_op,
  input  logic [31:0] ac_off,
  output logic        ac_done,
  output logic [2:0]  ac_fault,
  output logic [31:0] ac_addr,
  output logic        wb_req,
  output logic [63:0] wb_desc
);
  localparam logic [2:0] F_NONE  = 3'd0;
  localparam logic [2:0] F_CLASS = 3'd1;
  localparam logic [2:0] F_NP    = 3'd2;
  localparam logic [2:0] F_PRIV  = 3'd3;
  localparam logic [2:0] F_LIMIT = 3'd4;
  localparam logic [2:0] F_RIGHT = 3'd5;
  localparam logic [2:0] F_NOSEG = 3'd6;

  logic [63:0] dq;
  logic        vq;

  // load-side decode
  wire       l_s   = ld_desc[44];
  wire       l_e   = ld_desc[43];
  wire       l_dc  = ld_desc[42];
  wire       l_rw  = ld_desc[41];
  wire       l_p   = ld_desc[47];
  wire [1:0] l_dpl = ld_desc[46:45];
  wire [1:0] eff_pl = (ld_cpl > ld_rpl) ? ld_cpl : ld_rpl;

  wire class_bad = !l_s || (ld_code ? !l_e : (l_e && !l_rw));
  wire priv_bad  = ld_code ? (l_dc ? (ld_cpl < l_dpl) : (ld_cpl != l_dpl))
                           : (eff_pl > l_dpl);
  wire [2:0] ld_code_n = class_bad ? F_CLASS :
                         !l_p      ? F_NP    :
                         priv_bad  ? F_PRIV  : F_NONE;

  // access-side decode
  wire [31:0] base  = {dq[63:56], dq[39:16]};
  wire [19:0] lim20 = {dq[51:48], dq[15:0]};
  wire [31:0] elim  = dq[55] ? {lim20, 12'hFFF} : {12'h000, lim20};
  wire        is_code = dq[43];
  wire        exp_dn  = !is_code && dq[42];
  wire        in_lim  = exp_dn ? (ac_off > elim) : (ac_off <= elim);

  logic rights_ok;
  always_comb begin
    case (ac_op)
      2'd0:    rights_ok = !is_code || dq[41];
      2'd1:    rights_ok = !is_code && dq[41];
      2'd2:    rights_ok = is_code;
      default: rights_ok = 1'b0;
    endcase
  end

  wire [2:0] ac_code_n = !vq        ? F_NOSEG :
                         !rights_ok ? F_RIGHT :
                         !in_lim    ? F_LIMIT : F_NONE;
  wire ac_ok    = (ac_code_n == F_NONE);
  wire mark_acc = ac_valid && ac_ok && !dq[40] && !ld_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq <= '0; vq <= 1'b0;
      ld_done <= 1'b0; ld_fault <= F_NONE;
      ac_done <= 1'b0; ac_fault <= F_NONE; ac_addr <= '0;
      wb_req <= 1'b0; wb_desc <= '0;
    end else begin
      ld_done <= ld_valid;
      ac_done <= ac_valid;
      wb_req  <= mark_acc;
      if (ac_valid) begin
        ac_fault <= ac_code_n;
        ac_addr  <= ac_ok ? base + ac_off : 32'h0;
      end
      if (mark_acc) begin
        dq[40]  <= 1'b1;
        wb_desc <= dq | (64'h1 << 40);
      end
      if (ld_valid) begin
        ld_fault <= ld_code_n;
        vq       <= (ld_code_n == F_NONE);
        dq       <= ld_desc;
      end
    end
  end

  p_addr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_done && ac_fault != F_NONE) |-> (ac_addr == 32'h0));
  p_wb_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |=> !wb_req);
  p_wb_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (ac_done && ac_fault == F_NONE && wb_desc[40]));
  p_ok_needs_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_done && ac_fault == F_NONE) |-> $past(vq));
  p_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_done && ld_fault == F_NONE) |-> (vq && dq[47]));
  p_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ac_valid |=> ac_done);
endmodule

// File: tb/tb_seg_guard.sv
module tb_seg_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0, ld_code = 1'b0;
  logic [63:0] ld_desc = '0;
  logic [1:0] ld_rpl = '0, ld_cpl = '0, ac_op = '0;
  logic ac_valid = 1'b0;
  logic [31:0] ac_off = '0;
  logic ld_done, ac_done, wb_req;
  logic [2:0] ld_fault, ac_fault;
  logic [31:0] ac_addr;
  logic [63:0] wb_desc;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  seg_guard dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // type4 = {E, DC, RW, A}
  function automatic logic [63:0] mk(logic [31:0] b, logic [19:0] l, logic g,
      logic p, logic [1:0] dpl, logic s, logic [3:0] t);
    return {b[31:24], g, 1'b1, 2'b00, l[19:16], p, dpl, s, t, b[23:0], l[15:0]};
  endfunction

  task automatic load(logic [63:0] d, logic code, logic [1:0] rpl, logic [1:0] cpl,
                      output logic [2:0] f);
    @(negedge clk);
    ld_valid = 1'b1; ld_desc = d; ld_code = code; ld_rpl = rpl; ld_cpl = cpl;
    @(negedge clk);
    ld_valid = 1'b0;
    f = ld_fault;
    if (ld_done !== 1'b1) chk("R11 ld_done", {63'd0, ld_done}, 64'd1);
  endtask

  task automatic acc(logic [1:0] op, logic [31:0] off,
                     output logic [2:0] f, output logic [31:0] a, output logic w);
    @(negedge clk);
    ac_valid = 1'b1; ac_op = op; ac_off = off;
    @(negedge clk);
    ac_valid = 1'b0;
    f = ac_fault; a = ac_addr; w = wb_req;
    if (ac_done !== 1'b1) chk("R11 ac_done", {63'd0, ac_done}, 64'd1);
  endtask

  task automatic t_reset();
    logic [2:0] f; logic [31:0] a; logic w;
    chk("R11 reset ld_done", ld_done, 0);
    chk("R11 reset ac_done", ac_done, 0);
    chk("R11 reset wb_req", wb_req, 0);
    chk("R11 reset addr", ac_addr, 0);
    acc(2'd0, 32'h0, f, a, w);
    chk("R4 R11 no segment after reset", f, 6);
    chk("R9 addr zero", a, 0);
  endtask

  task automatic t_base_limit();
    logic [2:0] f; logic [31:0] a; logic w; logic [63:0] d;
    d = mk(32'h12345678, 20'h00FFF, 0, 1, 2'd3, 1, 4'b0010);
    load(d, 0, 2'd0, 2'd0, f);
    chk("R5 data load ok", f, 0);
    acc(2'd0, 32'h10, f, a, w);
    chk("R1 fault", f, 0);
    chk("R1 addr", a, 32'h12345688);
    chk("R10 first wb", w, 1);
    chk("R10 wb image", wb_desc, d | (64'h1 << 40));
    acc(2'd1, 32'hFFF, f, a, w);
    chk("R8 last byte ok", f, 0);
    chk("R10 no second wb", w, 0);
    acc(2'd0, 32'h1000, f, a, w);
    chk("R8 past limit", f, 4);
    chk("R9 addr zero", a, 0);
  endtask

  task automatic t_gran();
    logic [2:0] f; logic [31:0] a; logic w;
    load(mk(32'h00010000, 20'h00001, 1, 1, 2'd0, 1, 4'b0001), 0, 2'd0, 2'd0, f);
    chk("R2 load", f, 0);
    acc(2'd0, 32'h1FFF, f, a, w);
    chk("R2 page top ok", f, 0);
    chk("R2 addr", a, 32'h00011FFF);
    chk("R10 A already set no wb", w, 0);
    acc(2'd0, 32'h2000, f, a, w);
    chk("R2 page past limit", f, 4);
  endtask

  task automatic t_rights();
    logic [2:0] f; logic [31:0] a; logic w;
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd0, 1, 4'b0000), 0, 2'd0, 2'd0, f);
    acc(2'd1, 32'h0, f, a, w);  chk("R7 write ro data", f, 5);
    acc(2'd0, 32'h0, f, a, w);  chk("R7 read data", f, 0);
    acc(2'd2, 32'h0, f, a, w);  chk("R7 fetch data", f, 5);
    acc(2'd3, 32'h0, f, a, w);  chk("R7 invalid op", f, 5);
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd0, 1, 4'b1010), 1, 2'd0, 2'd0, f);
    chk("R5 code load", f, 0);
    acc(2'd0, 32'h0, f, a, w);  chk("R7 read readable code", f, 0);
    acc(2'd1, 32'h0, f, a, w);  chk("R7 write code", f, 5);
    acc(2'd2, 32'h0, f, a, w);  chk("R7 fetch code", f, 0);
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd0, 1, 4'b1000), 1, 2'd0, 2'd0, f);
    acc(2'd0, 32'h0, f, a, w);  chk("R7 read exec-only", f, 5);
    acc(2'd1, 32'h200000, f, a, w); chk("R9 rights before limit", f, 5);
  endtask

  task automatic t_expdown();
    logic [2:0] f; logic [31:0] a; logic w;
    load(mk(32'h00002000, 20'h00FFF, 0, 1, 2'd0, 1, 4'b0110), 0, 2'd0, 2'd0, f);
    acc(2'd1, 32'h0FFF, f, a, w); chk("R8 expdown at limit", f, 4);
    acc(2'd1, 32'h1000, f, a, w); chk("R8 expdown above", f, 0);
    chk("R1 expdown addr", a, 32'h3000);
    acc(2'd0, 32'hFFFFFFFF, f, a, w); chk("R8 expdown top", f, 0);
    chk("R1 wrap addr", a, 32'h00001FFF);
    load(mk(32'h0, 20'h00FFF, 0, 1, 2'd0, 1, 4'b1110), 1, 2'd0, 2'd0, f);
    acc(2'd2, 32'h0FFF, f, a, w); chk("R8 conforming code is not expdown", f, 0);
  endtask

  task automatic t_class_np();
    logic [2:0] f; logic [31:0] a; logic w;
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd0, 0, 4'b0010), 0, 2'd0, 2'd0, f);
    chk("R3 system desc", f, 1);
    acc(2'd0, 32'h0, f, a, w); chk("R4 no seg after fail", f, 6);
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd0, 1, 4'b0010), 1, 2'd0, 2'd0, f);
    chk("R3 data into code", f, 1);
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd0, 1, 4'b1000), 0, 2'd0, 2'd0, f);
    chk("R3 exec-only into data", f, 1);
    load(mk(32'h0, 20'hFFFFF, 0, 0, 2'd0, 1, 4'b0010), 0, 2'd0, 2'd0, f);
    chk("R4 not present", f, 2);
    acc(2'd0, 32'h0, f, a, w);
    chk("R4 no address", f, 6);
    chk("R4 addr zero", a, 0);
    load(mk(32'h0, 20'hFFFFF, 0, 0, 2'd0, 0, 4'b0010), 0, 2'd0, 2'd0, f);
    chk("R6 class over np", f, 1);
    load(mk(32'h0, 20'hFFFFF, 0, 0, 2'd0, 1, 4'b0010), 0, 2'd3, 2'd3, f);
    chk("R6 np over priv", f, 2);
  endtask

  task automatic t_priv();
    logic [2:0] f;
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd1, 1, 4'b0010), 0, 2'd2, 2'd0, f);
    chk("R5 data rpl too weak", f, 3);
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd1, 1, 4'b0010), 0, 2'd1, 2'd1, f);
    chk("R5 data equal ok", f, 0);
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd2, 1, 4'b1010), 1, 2'd0, 2'd1, f);
    chk("R5 nonconf mismatch", f, 3);
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd2, 1, 4'b1010), 1, 2'd0, 2'd2, f);
    chk("R5 nonconf equal", f, 0);
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd1, 1, 4'b1110), 1, 2'd0, 2'd3, f);
    chk("R5 conf outer ok", f, 0);
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd1, 1, 4'b1110), 1, 2'd0, 2'd0, f);
    chk("R5 conf inner refused", f, 3);
  endtask

  task automatic t_same_cycle();
    logic [2:0] f; logic [31:0] a; logic w;
    load(mk(32'h0, 20'hFFFFF, 0, 1, 2'd0, 1, 4'b0010), 0, 2'd0, 2'd0, f);
    @(negedge clk);
    ld_valid = 1'b1; ld_desc = mk(32'h100, 20'hFFFFF, 0, 1, 2'd0, 1, 4'b0010);
    ac_valid = 1'b1; ac_op = 2'd0; ac_off = 32'h4;
    @(negedge clk);
    ld_valid = 1'b0; ac_valid = 1'b0;
    chk("R10 no wb with load", wb_req, 0);
    chk("R1 old segment used", ac_addr, 32'h4);
    acc(2'd0, 32'h4, f, a, w);
    chk("R10 wb on new segment", w, 1);
    chk("R1 new base", a, 32'h104);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_limit();
    t_gran();
    t_rights();
    t_expdown();
    t_class_np();
    t_priv();
    t_same_cycle();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end
endmodule